// File: doc/BRIEF.md
# Indirect Byte-Wide Configuration Write Port

This block lets a host with an 8-bit data bus and a 3-bit address load 32-bit configuration words into a bank of internal registers. The host first writes the word one byte at a time into four staging lanes. It then writes an 8-bit destination index. A fixed number of core clocks after that index is taken, a single commit pulse copies the staged word into the selected register. The host's active-low write strobe is not tied to the core clock. The block passes it through a flop synchronizer and uses its rising edge to sample the bus.

Two destinations are double-buffered: a gain word and a carrier-frequency word. Each has its own holding copy and its own active copy. An enable bit in configuration register 0 picks how the active copy changes. With the bit clear, a commit writes the active copy straight away. With the bit set, a commit fills only the holding copy, and the active copy takes the holding value on a clock where the matching external event input is high. A further bus address sets an 8-bit source selector, which a separate read path uses.

Top module: `cfg_write_port`

## Requirements
- R1: After synchronous reset, every configuration register, both holding copies, both active copies and `src_sel` are zero, and `busy` is low.
- R2: Bus addresses 0, 1, 2 and 3 stage bytes that land in bits 7:0, 15:8, 23:16 and 31:24 of the committed word.
- R3: `host_addr` and `host_data` are taken at the third rising `clk` edge after `host_we_n` goes from 0 to 1. The host must hold them stable until that edge.
- R4: A take at address 4 latches `host_data` as the destination index. On the fourth clock edge after that take, the staged word is written to configuration register `index` when `index` < NUM_CFG.
- R5: `busy` rises at the address-4 take and falls at the commit edge. An address-4 take that happens while `busy` is high is discarded and does not retarget or restart the pending commit.
- R6: A take at address 5 loads `host_data` into the `src_sel` output.
- R7: Takes at addresses 6 and 7 change nothing. A commit to an index that is neither below NUM_CFG nor equal to 0x20 or 0x21 changes nothing.
- R8: A commit to index 0x20 loads the gain holding copy. It also loads `gain_act` when bit 1 of configuration register 0 is clear. While that bit is set, `gain_act` takes the holding copy on every edge where `evt_gain` is high, and it is otherwise left as it is.
- R9: A commit to index 0x21 loads a separate frequency holding copy. It also loads `freq_act` when bit 0 of configuration register 0 is clear. While that bit is set, `freq_act` takes its holding copy on every edge where `evt_freq` is high.
- R10: Staged bytes keep their value after a commit, so a second index write commits the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we_n | input | 1 | Active-low host write strobe, asynchronous to clk |
| host_addr | input | 3 | Host register select |
| host_data | input | 8 | Host write data |
| evt_gain | input | 1 | Event that moves gain holding to active |
| evt_freq | input | 1 | Event that moves frequency holding to active |
| cfg_flat | output | NUM_CFG*32 | Configuration registers, register i in bits 32i+31:32i |
| gain_act | output | 32 | Active gain word |
| freq_act | output | 32 | Active frequency word |
| src_sel | output | 8 | Read source selector |
| busy | output | 1 | Commit pending |

## Verification
The tests write a distinct byte in each lane before a commit, which shows whether any lane ends up in the wrong position. Recommitting without restaging shows that the staged bytes are kept. A back-to-back pair of index writes, spaced so that the second take falls on the commit edge, separates "discard while busy" from "retarget". The double-buffered words are driven with the enable clear and then set, with events pulsed one at a time. This shows direct writes, held writes, and that the gain and frequency holding copies are independent. A hand-timed strobe checks that the bus take happens exactly at the third edge after the strobe rises and not earlier.

// File: rtl/cfg_wp_pkg.sv
package cfg_wp_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam logic [2:0] ADDR_DEST = 3'd4;
  localparam logic [2:0] ADDR_SRC  = 3'd5;
endpackage

// File: rtl/cfg_wp_strobe.sv
module cfg_wp_strobe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);
  localparam int CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[CHAIN-2:0], strobe_n};
  end

  assign rise = chain[CHAIN-2] & ~chain[CHAIN-1];
endmodule

// File: rtl/cfg_wp_stage.sv
module cfg_wp_stage
  import cfg_wp_pkg::*;
#(
  parameter int DEST_W = 8,
  parameter int DELAY  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] data,
  output logic [WORD_W-1:0] word,
  output logic [DEST_W-1:0] dest,
  output logic [BYTE_W-1:0] src_sel,
  output logic              commit,
  output logic              busy
);
  localparam int CNT_W = (DELAY > 2) ? $clog2(DELAY) : 1;
  logic [BYTE_W-1:0] lane_q [LANES];
  logic [CNT_W-1:0]  cnt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_q[l] <= '0;
      else if (take && addr == 3'(l)) lane_q[l] <= data;
    end
    assign word[l*BYTE_W +: BYTE_W] = lane_q[l];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      commit <= 1'b0;
      busy   <= 1'b0;
      dest   <= '0;
    end else begin
      commit <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) commit <= 1'b1;
      end
      if (commit) busy <= 1'b0;
      if (take && addr == ADDR_DEST && !busy) begin
        dest <= data[DEST_W-1:0];
        cnt  <= CNT_W'(DELAY - 1);
        busy <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) src_sel <= '0;
    else if (take && addr == ADDR_SRC) src_sel <= data;
  end
endmodule

// File: rtl/cfg_wp_dbuf.sv
module cfg_wp_dbuf
  import cfg_wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              evt_en,
  input  logic              evt,
  output logic [WORD_W-1:0] act
);
  logic [WORD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      act  <= '0;
    end else begin
      if (load) hold <= word;
      if (load && !evt_en)     act <= word;
      else if (evt && evt_en)  act <= hold;
    end
  end
endmodule

// File: rtl/cfg_wp_bank.sv
module cfg_wp_bank
  import cfg_wp_pkg::*;
#(
  parameter int                NUM_CFG     = 8,
  parameter int                DEST_W      = 8,
  parameter logic [DEST_W-1:0] GAIN_DEST   = 8'h20,
  parameter logic [DEST_W-1:0] FREQ_DEST   = 8'h21,
  parameter int                GAIN_EN_BIT = 1,
  parameter int                FREQ_EN_BIT = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit,
  input  logic [DEST_W-1:0]         dest,
  input  logic [WORD_W-1:0]         word,
  input  logic                      evt_gain,
  input  logic                      evt_freq,
  output logic [NUM_CFG*WORD_W-1:0] cfg_flat,
  output logic [WORD_W-1:0]         gain_act,
  output logic [WORD_W-1:0]         freq_act
);
  logic [WORD_W-1:0] cfg_q [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfg_q[i] <= '0;
      else if (commit && dest == DEST_W'(i)) cfg_q[i] <= word;
    end
    assign cfg_flat[i*WORD_W +: WORD_W] = cfg_q[i];
  end

  cfg_wp_dbuf u_gain (
    .clk(clk), .rst(rst), .load(commit && dest == GAIN_DEST), .word(word),
    .evt_en(cfg_q[0][GAIN_EN_BIT]), .evt(evt_gain), .act(gain_act)
  );

  cfg_wp_dbuf u_freq (
    .clk(clk), .rst(rst), .load(commit && dest == FREQ_DEST), .word(word),
    .evt_en(cfg_q[0][FREQ_EN_BIT]), .evt(evt_freq), .act(freq_act)
  );
endmodule

// File: rtl/cfg_write_port.sv
module cfg_write_port
  import cfg_wp_pkg::*;
#(
  parameter int                NUM_CFG     = 8,
  parameter int                DEST_W      = 8,
  parameter int                COMMIT_DLY  = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DEST_W-1:0] GAIN_DEST   = 8'h20,
  parameter logic [DEST_W-1:0] FREQ_DEST   = 8'h21,
  parameter int                GAIN_EN_BIT = 1,
  parameter int                FREQ_EN_BIT = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_we_n,
  input  logic [2:0]                host_addr,
  input  logic [BYTE_W-1:0]         host_data,
  input  logic                      evt_gain,
  input  logic                      evt_freq,
  output logic [NUM_CFG*WORD_W-1:0] cfg_flat,
  output logic [WORD_W-1:0]         gain_act,
  output logic [WORD_W-1:0]         freq_act,
  output logic [BYTE_W-1:0]         src_sel,
  output logic                      busy
);
  logic              take;
  logic              commit_pulse;
  logic [WORD_W-1:0] staged;
  logic [DEST_W-1:0] dest_idx;

  cfg_wp_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst(rst), .strobe_n(host_we_n), .rise(take)
  );

  cfg_wp_stage #(.DEST_W(DEST_W), .DELAY(COMMIT_DLY)) u_stage (
    .clk(clk), .rst(rst), .take(take), .addr(host_addr), .data(host_data),
    .word(staged), .dest(dest_idx), .src_sel(src_sel),
    .commit(commit_pulse), .busy(busy)
  );

  cfg_wp_bank #(
    .NUM_CFG(NUM_CFG), .DEST_W(DEST_W), .GAIN_DEST(GAIN_DEST),
    .FREQ_DEST(FREQ_DEST), .GAIN_EN_BIT(GAIN_EN_BIT), .FREQ_EN_BIT(FREQ_EN_BIT)
  ) u_bank (
    .clk(clk), .rst(rst), .commit(commit_pulse), .dest(dest_idx), .word(staged),
    .evt_gain(evt_gain), .evt_freq(evt_freq), .cfg_flat(cfg_flat),
    .gain_act(gain_act), .freq_act(freq_act)
  );
endmodule

// File: rtl/cfg_write_port_chk.sv
module cfg_write_port_chk #(
  parameter int WORD_W = 32,
  parameter int DELAY  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              commit,
  input logic              evt_gain,
  input logic              evt_freq,
  input logic [WORD_W-1:0] gain_act,
  input logic [WORD_W-1:0] freq_act
);
  logic [7:0] busy_cycles;

  always_ff @(posedge clk) begin
    if (rst)       busy_cycles <= '0;
    else if (busy) busy_cycles <= busy_cycles + 8'd1;
    else           busy_cycles <= '0;
  end

  // R4: commit fires in the last busy cycle, DELAY edges after the take
  a_r4_commit_delay: assert property (@(posedge clk) disable iff (rst)
    commit |-> (busy && busy_cycles == 8'(DELAY - 1)));

  // R4: commit is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R5: busy drops at the commit edge
  a_r5_busy_clears: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);

  // R8: without an event or a commit the active gain keeps its value
  a_r8_gain_holds: assert property (@(posedge clk) disable iff (rst)
    (!evt_gain && !commit) |=> $stable(gain_act));

  // R9: without an event or a commit the active frequency keeps its value
  a_r9_freq_holds: assert property (@(posedge clk) disable iff (rst)
    (!evt_freq && !commit) |=> $stable(freq_act));
endmodule

bind cfg_write_port cfg_write_port_chk #(.WORD_W(cfg_wp_pkg::WORD_W), .DELAY(COMMIT_DLY)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .commit(commit_pulse),
  .evt_gain(evt_gain), .evt_freq(evt_freq), .gain_act(gain_act), .freq_act(freq_act)
);

// File: tb/cfg_write_port_test.sv
`timescale 1ns/1ps
module cfg_write_port_test;
  localparam int NUM_CFG = 8;
  localparam logic [7:0] GDEST = 8'h20;
  localparam logic [7:0] FDEST = 8'h21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we_n = 1'b1;
  logic [2:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic evt_gain = 1'b0, evt_freq = 1'b0;
  logic [NUM_CFG*32-1:0] cfg_flat;
  logic [31:0] gain_act, freq_act;
  logic [7:0] src_sel;
  logic busy;

  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  cfg_write_port uut (
    .clk(clk), .rst(rst), .host_we_n(host_we_n), .host_addr(host_addr),
    .host_data(host_data), .evt_gain(evt_gain), .evt_freq(evt_freq),
    .cfg_flat(cfg_flat), .gain_act(gain_act), .freq_act(freq_act),
    .src_sel(src_sel), .busy(busy)
  );

  // Behavioural reference model
  logic [31:0] m_cfg [NUM_CFG];
  logic [31:0] m_word, m_gh, m_ga, m_fh, m_fa;
  logic [7:0]  m_src, m_dest;
  logic        m_busy, m_prev;
  int          cap_cd, com_cd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cfg[i]) m_cfg[i] = '0;
      m_word = '0; m_gh = '0; m_ga = '0; m_fh = '0; m_fa = '0;
      m_src = '0; m_dest = '0; m_busy = 1'b0; m_prev = 1'b1;
      cap_cd = 0; com_cd = 0;
    end else begin
      logic en_g, en_f, old_busy, do_com, direct_g, direct_f;
      logic [31:0] old_gh, old_fh;
      en_g = m_cfg[0][1]; en_f = m_cfg[0][0];
      old_gh = m_gh; old_fh = m_fh; old_busy = m_busy;
      do_com = (com_cd == 1);
      if (com_cd > 0) com_cd--;
      direct_g = 1'b0; direct_f = 1'b0;
      if (do_com) begin
        m_busy = 1'b0;
        if (m_dest < NUM_CFG) m_cfg[m_dest] = m_word;
        if (m_dest == GDEST) begin m_gh = m_word; if (!en_g) begin m_ga = m_word; direct_g = 1'b1; end end
        if (m_dest == FDEST) begin m_fh = m_word; if (!en_f) begin m_fa = m_word; direct_f = 1'b1; end end
      end
      if (!direct_g && evt_gain && en_g) m_ga = old_gh;
      if (!direct_f && evt_freq && en_f) m_fa = old_fh;
      if (cap_cd == 1) begin
        cap_cd = 0;
        case (host_addr)
          3'd0: m_word[7:0]   = host_data;
          3'd1: m_word[15:8]  = host_data;
          3'd2: m_word[23:16] = host_data;
          3'd3: m_word[31:24] = host_data;
          3'd4: if (!old_busy) begin m_dest = host_data; m_busy = 1'b1; com_cd = 4; end
          3'd5: m_src = host_data;
          default: ;
        endcase
      end else if (cap_cd > 1) cap_cd--;
      if (host_we_n && !m_prev) cap_cd = 2;
      m_prev = host_we_n;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NUM_CFG; i++) cmp("R4 cfg", cfg_flat[i*32 +: 32], m_cfg[i]);
      cmp("R8 gain_act", gain_act, m_ga);
      cmp("R9 freq_act", freq_act, m_fa);
      cmp("R6 src_sel", {24'd0, src_sel}, {24'd0, m_src});
      cmp("R5 busy", {31'd0, busy}, {31'd0, m_busy});
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_data = d; host_we_n = 1'b0;
    repeat (3) @(negedge clk);
    host_we_n = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic host_write_fast(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_data = d; host_we_n = 1'b0;
    @(negedge clk); host_we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_word(input logic [31:0] w);
    for (int l = 0; l < 4; l++) host_write(3'(l), w[l*8 +: 8]);
  endtask

  task automatic pulse_evt(input bit gain);
    @(negedge clk); if (gain) evt_gain = 1'b1; else evt_freq = 1'b1;
    @(negedge clk); evt_gain = 1'b0; evt_freq = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  logic [7:0] src_before;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    cmp("R1 cfg0", cfg_flat[31:0], 32'h0);
    cmp("R1 gain", gain_act, 32'h0);
    cmp("R1 freq", freq_act, 32'h0);
    cmp("R1 busy", {31'd0, busy}, 32'h0);

    // R2: byte lane placement
    load_word(32'h44332211);
    host_write(3'd4, 8'd2);
    cmp("R2 lanes", cfg_flat[2*32 +: 32], 32'h44332211);

    // R10: staged bytes survive a commit
    host_write(3'd4, 8'd3);
    cmp("R10 reuse", cfg_flat[3*32 +: 32], 32'h44332211);

    // R3: take at third edge after strobe rise
    src_before = src_sel;
    @(negedge clk); host_addr = 3'd5; host_data = 8'hA5; host_we_n = 1'b0;
    repeat (3) @(negedge clk);
    host_we_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R3 not yet", {24'd0, src_sel}, {24'd0, src_before});
    @(negedge clk);
    cmp("R3 taken", {24'd0, src_sel}, 32'h000000A5);
    cmp("R6 src", {24'd0, src_sel}, 32'h000000A5);
    repeat (4) @(negedge clk);

    // R7: ignored addresses and unimplemented destination
    load_word(32'hDEADBEEF);
    host_write(3'd6, 8'h01);
    host_write(3'd7, 8'h02);
    host_write(3'd4, 8'h40);
    cmp("R7 cfg1", cfg_flat[1*32 +: 32], 32'h0);
    cmp("R7 cfg2", cfg_flat[2*32 +: 32], 32'h44332211);
    cmp("R7 src", {24'd0, src_sel}, 32'h000000A5);
    cmp("R7 gain", gain_act, 32'h0);

    // R5: second index take while busy is discarded
    host_write_fast(3'd4, 8'd1);
    host_write_fast(3'd4, 8'd5);
    repeat (8) @(negedge clk);
    cmp("R5 first", cfg_flat[1*32 +: 32], 32'hDEADBEEF);
    cmp("R5 second", cfg_flat[5*32 +: 32], 32'h0);

    // R8: enable clear writes active gain directly
    load_word(32'h12345678);
    host_write(3'd4, GDEST);
    cmp("R8 direct", gain_act, 32'h12345678);
    // R9: enable clear writes active frequency directly
    load_word(32'h0BADF00D);
    host_write(3'd4, FDEST);
    cmp("R9 direct", freq_act, 32'h0BADF00D);

    // enable both event transfers
    load_word(32'h00000003);
    host_write(3'd4, 8'd0);
    load_word(32'hAAAA5555);
    host_write(3'd4, GDEST);
    cmp("R8 held", gain_act, 32'h12345678);
    load_word(32'h1357_9BDF);
    host_write(3'd4, FDEST);
    cmp("R9 held", freq_act, 32'h0BADF00D);
    pulse_evt(1'b0);
    cmp("R9 evt", freq_act, 32'h13579BDF);
    cmp("R8 evt other", gain_act, 32'h12345678);
    pulse_evt(1'b1);
    cmp("R8 evt", gain_act, 32'hAAAA5555);
    cmp("R9 evt other", freq_act, 32'h13579BDF);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule